// File: doc/BRIEF.md
# Byte-Lane Load/Store Data Aligner

This block sits between a processor core and a memory that is one 32-bit word wide. On the store side it takes a register value, an access size and the low address bits. It returns the write word with the stored element moved into the correct byte lanes, together with a per-lane write-enable mask. On the load side it takes the word read from memory, the same size and address bits, and a signed/unsigned flag. It returns the register value: the addressed element is moved down to bit 0 and the upper bits are filled with zeros or with copies of its sign bit.

Byte-lane numbering follows an endianness setting. That setting is held in a register inside the block, is little-endian after reset, and changes only when a configuration write strobe is pulsed. Both data paths are combinational; only the endianness bit is stored. A halfword access at an odd byte address is reported as misaligned, and no lane is enabled for it.

Top module: `ls_lane_aligner`

## Requirements
- R1: After reset the block numbers lanes little-endian: a byte load at offset 0 of word 0x11223344 returns 0x00000044.
- R2: On a clock edge with `cfg_wr`=1, the endianness register takes `cfg_big` (1 = big-endian). With `cfg_wr`=0 it keeps its value.
- R3: A byte at offset k (k = `addr_lo`) sits in lane k (bits 8k+7:8k) when little-endian and in lane 3-k when big-endian. In big-endian mode a byte load at offset 0 of 0x11223344 returns 0x00000011.
- R4: For a byte store (`acc_size`=0), `wr_data` holds `st_data[7:0]` in the selected lane and zeros in all other lanes. `byte_en` has exactly that one bit set.
- R5: For an aligned halfword store (`acc_size`=1), `st_data[15:0]` goes to bits 15:0 when (little-endian and `addr_lo`[1]=0) or (big-endian and `addr_lo`[1]=1), and to bits 31:16 otherwise. Zeros fill the rest, and `byte_en` is 0011 or 1100 to match.
- R6: For a word store (`acc_size`=2), `wr_data` equals `st_data` and `byte_en`=1111, whatever `addr_lo` and the endianness are.
- R7: A byte load returns the selected byte in bits 7:0. Bits 31:8 are zero when `ld_signed`=0 and copies of the byte's bit 7 when `ld_signed`=1.
- R8: A halfword load returns the halfword chosen as in R5 in bits 15:0. Bits 31:16 are zero when `ld_signed`=0 and copies of bit 15 when `ld_signed`=1.
- R9: A word load returns `rd_word` unchanged; `ld_signed` and `addr_lo` have no effect on it.
- R10: A halfword access with `addr_lo`[0]=1 sets `misalign`=1 and forces `byte_en`=0000. `wr_data` and `ld_result` then follow the aligned halfword chosen by `addr_lo`[1]. For every other access `misalign`=0.
- R11: Size code 3 behaves exactly like a word access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the endianness register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Endianness write strobe |
| cfg_big | input | 1 | Endianness value written by `cfg_wr` (1 = big-endian) |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| addr_lo | input | 2 | Byte offset of the access inside the word |
| ld_signed | input | 1 | 1 sign-extends byte and halfword loads |
| st_data | input | 32 | Register value to store |
| wr_data | output | 32 | Store data placed in its byte lanes |
| byte_en | output | 4 | Per-lane write enable |
| rd_word | input | 32 | Word read from memory |
| ld_result | output | 32 | Aligned and extended load value |
| misalign | output | 1 | Odd-address halfword access |

## Verification
The bench targets several corner cases.
- Lane reversal between the two endianness modes, at every offset and every size: a design that ignores the mode would return 0x44 where 0x11 is expected.
- Negative bytes and halfwords under both signed and unsigned loads: a design that extends from the wrong bit, or extends always, corrupts bits 31:8 or 31:16.
- Odd halfword offsets: a design that writes anyway shows a nonzero `byte_en` with `misalign` high.
- Word accesses with nonzero low address bits: a design that shifts them moves data out of place.
- Endianness changes with the strobe held low: a register that follows `cfg_big` directly flips the lane mapping without a write.

// File: rtl/lsalign_pkg.sv
package lsalign_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lsalign_lane_ctl.sv
// Works out where the accessed element lives in the word.
// base     : lowest lane that holds the element.
// n_lanes  : element width in lanes.
// lane_sel : lanes covered by the element.
module lsalign_lane_ctl
  import lsalign_pkg::*;
#(
  parameter  int NLANES = 4,
  localparam int AW     = $clog2(NLANES),
  localparam int CW     = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        size,
  input  logic [AW-1:0]     addr,
  input  logic              big,
  output logic [AW-1:0]     base,
  output logic [CW-1:0]     n_lanes,
  output logic [NLANES-1:0] lane_sel,
  output logic [NLANES-1:0] byte_en,
  output logic              misalign
);
  logic [AW-1:0]   align_off;
  logic [NLANES:0] low_mask;

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE: n_lanes = CW'(1);
      SZ_HALF: n_lanes = CW'(2);
      default: n_lanes = CW'(NLANES);
    endcase
    // The address is rounded down to the element size.
    align_off = addr & ~AW'(n_lanes - CW'(1));
    if (big) base = AW'(CW'(NLANES) - n_lanes - {1'b0, align_off});
    else     base = align_off;
    low_mask = ((NLANES+1)'(1) << n_lanes) - (NLANES+1)'(1);
    lane_sel = low_mask[NLANES-1:0] << base;
    misalign = (acc_size_e'(size) == SZ_HALF) && addr[0];
    byte_en  = misalign ? '0 : lane_sel;
  end

  // R4: a byte access enables exactly one lane
  p_byte_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (size == SZ_BYTE) |-> ($countones(byte_en) == 1));

  // R5: an aligned halfword enables two neighbouring lanes
  p_half_adjacent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (size == SZ_HALF && !addr[0]) |->
      ($countones(byte_en) == 2 && (byte_en & (byte_en >> 1)) != '0));

  // R10: a misaligned halfword writes no lane
  p_misalign_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (size == SZ_HALF && addr[0]) |-> (misalign && byte_en == '0));

  // R6 / R11: word-sized codes enable every lane
  p_word_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (size[1]) |-> (&byte_en && !misalign));
endmodule

// File: rtl/lsalign_store.sv
// Moves the low n_lanes lanes of the register value up to start at lane base.
module lsalign_store #(
  parameter  int LANE_W = 8,
  parameter  int NLANES = 4,
  localparam int DATA_W = LANE_W * NLANES,
  localparam int AW     = $clog2(NLANES)
) (
  input  logic [DATA_W-1:0] st_data,
  input  logic [AW-1:0]     base,
  input  logic [NLANES-1:0] lane_sel,
  output logic [DATA_W-1:0] wr_data
);
  logic [LANE_W-1:0] st_lane [NLANES];

  for (genvar j = 0; j < NLANES; j++) begin : g_lane
    logic [AW-1:0] src;
    assign st_lane[j] = st_data[j*LANE_W +: LANE_W];
    always_comb begin
      src = AW'(j) - base;
      wr_data[j*LANE_W +: LANE_W] = lane_sel[j] ? st_lane[src] : '0;
    end
  end
endmodule

// File: rtl/lsalign_load.sv
// Brings the element down to lane 0 and fills the upper lanes.
module lsalign_load #(
  parameter  int LANE_W = 8,
  parameter  int NLANES = 4,
  localparam int DATA_W = LANE_W * NLANES,
  localparam int AW     = $clog2(NLANES),
  localparam int CW     = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rd_word,
  input  logic [AW-1:0]     base,
  input  logic [CW-1:0]     n_lanes,
  input  logic              ld_signed,
  output logic [DATA_W-1:0] ld_result
);
  logic [LANE_W-1:0] rd_lane [NLANES];
  logic [AW-1:0]     top_lane;
  logic              fill_bit;

  always_comb begin
    top_lane = base + AW'(n_lanes - CW'(1));
    fill_bit = ld_signed & rd_lane[top_lane][LANE_W-1];
  end

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    logic [AW-1:0] src;
    logic          in_rng;
    assign rd_lane[k] = rd_word[k*LANE_W +: LANE_W];
    always_comb begin
      src    = base + AW'(k);
      in_rng = (CW'(k) < n_lanes);
      ld_result[k*LANE_W +: LANE_W] = in_rng ? rd_lane[src] : {LANE_W{fill_bit}};
    end
  end

  // R7: an unsigned single-lane load leaves the upper lanes at zero
  p_ubyte_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (n_lanes == CW'(1) && !ld_signed) |-> (ld_result[DATA_W-1:LANE_W] == '0));

  // R7: a signed single-lane load copies the top bit of the byte upward
  p_sbyte_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (n_lanes == CW'(1) && ld_signed) |->
      (ld_result[DATA_W-1:LANE_W] == {(DATA_W-LANE_W){ld_result[LANE_W-1]}}));

  // R8: an unsigned two-lane load leaves the upper half at zero
  p_uhalf_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (n_lanes == CW'(2) && !ld_signed) |-> (ld_result[DATA_W-1:2*LANE_W] == '0));

  // R9: a full-word load is the memory word
  p_word_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (n_lanes == CW'(NLANES)) |-> (ld_result == rd_word));
endmodule

// File: rtl/ls_lane_aligner.sv
module ls_lane_aligner #(
  parameter  int LANE_W = 8,
  parameter  int NLANES = 4,
  localparam int DATA_W = LANE_W * NLANES,
  localparam int AW     = $clog2(NLANES),
  localparam int CW     = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_big,
  input  logic [1:0]        acc_size,
  input  logic [AW-1:0]     addr_lo,
  input  logic              ld_signed,
  input  logic [DATA_W-1:0] st_data,
  output logic [DATA_W-1:0] wr_data,
  output logic [NLANES-1:0] byte_en,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] ld_result,
  output logic              misalign
);
  logic              big_q, big_d;
  logic [AW-1:0]     base;
  logic [CW-1:0]     n_lanes;
  logic [NLANES-1:0] lane_sel;

  // Endianness register: next state, then storage.
  always_comb big_d = cfg_wr ? cfg_big : big_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) big_q <= 1'b0;
    else        big_q <= big_d;
  end

  // R2: the setting holds without a write strobe
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(big_q));

  // R2: a write strobe loads the requested setting
  p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (big_q == $past(cfg_big)));

  lsalign_lane_ctl #(.NLANES(NLANES)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .size     (acc_size),
    .addr     (addr_lo),
    .big      (big_q),
    .base     (base),
    .n_lanes  (n_lanes),
    .lane_sel (lane_sel),
    .byte_en  (byte_en),
    .misalign (misalign)
  );

  lsalign_store #(.LANE_W(LANE_W), .NLANES(NLANES)) u_store (
    .st_data  (st_data),
    .base     (base),
    .lane_sel (lane_sel),
    .wr_data  (wr_data)
  );

  lsalign_load #(.LANE_W(LANE_W), .NLANES(NLANES)) u_load (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_word   (rd_word),
    .base      (base),
    .n_lanes   (n_lanes),
    .ld_signed (ld_signed),
    .ld_result (ld_result)
  );
endmodule

// File: tb/ls_lane_aligner_bench.sv
`timescale 1ns/1ps
module ls_lane_aligner_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_big = 1'b0;
  logic [1:0]  acc_size = 2'd0, addr_lo = 2'd0;
  logic        ld_signed = 1'b0;
  logic [31:0] st_data = '0, rd_word = '0;
  logic [31:0] wr_data, ld_result;
  logic [3:0]  byte_en;
  logic        misalign;

  int  checks = 0, failures = 0;
  bit  done = 0;
  bit  mbig = 0;     // model of the endianness setting

  always #10 clk = ~clk;   // 50 MHz

  ls_lane_aligner u_ls_lane_aligner (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_big(cfg_big),
    .acc_size(acc_size), .addr_lo(addr_lo), .ld_signed(ld_signed),
    .st_data(st_data), .wr_data(wr_data), .byte_en(byte_en),
    .rd_word(rd_word), .ld_result(ld_result), .misalign(misalign)
  );

  // Behavioural model: the element has nb bytes. In memory order it starts
  // at offset off rounded down to nb. pos is the word lane holding its
  // least significant byte.
  task automatic model(output logic [31:0] wd, output logic [31:0] ld,
                       output logic [3:0] be, output logic mis);
    int nb, start, pos;
    nb    = (acc_size == 0) ? 1 : (acc_size == 1) ? 2 : 4;
    start = (int'(addr_lo) / nb) * nb;
    pos   = mbig ? (4 - start - nb) : start;
    mis   = (acc_size == 1) && addr_lo[0];
    wd = '0; ld = '0; be = '0;
    for (int b = 0; b < nb; b++) begin
      wd[8*(pos+b) +: 8] = st_data[8*b +: 8];
      ld[8*b +: 8]       = rd_word[8*(pos+b) +: 8];
      be[pos+b]          = 1'b1;
    end
    if (mis) be = '0;
    if (nb < 4 && ld_signed && ld[8*nb-1])
      for (int i = 8*nb; i < 32; i++) ld[i] = 1'b1;
  endtask

  function automatic string tag_of();
    if (acc_size == 1 && addr_lo[0]) return "R10";
    case (acc_size)
      2'd0: return "R4/R7";
      2'd1: return "R5/R8";
      2'd2: return "R6/R9";
      default: return "R11";
    endcase
  endfunction

  task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Compare every output with the model (called away from the clock edge).
  task automatic compare_all();
    logic [31:0] ewd, eld;
    logic [3:0]  ebe;
    logic        emis;
    string t;
    model(ewd, eld, ebe, emis);
    t = tag_of();
    check32(t, "wr_data",   wr_data,   ewd);
    check32(t, "ld_result", ld_result, eld);
    check32(t, "byte_en",   {28'd0, byte_en},  {28'd0, ebe});
    check32(t, "misalign",  {31'd0, misalign}, {31'd0, emis});
  endtask

  task automatic apply(input logic [1:0] sz, input logic [1:0] ad, input logic sg,
                       input logic [31:0] sd, input logic [31:0] rw);
    acc_size = sz; addr_lo = ad; ld_signed = sg; st_data = sd; rd_word = rw;
  endtask

  // Write the endianness setting through the strobe; the model follows at the edge.
  task automatic set_endian(input logic b);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_big = b;
    @(negedge clk);
    cfg_wr = 1'b0;
    mbig = b;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: little-endian after reset
    apply(2'd0, 2'd0, 1'b0, 32'h0, 32'h11223344);
    #1;
    check32("R1", "reset byte load", ld_result, 32'h00000044);
    check32("R1", "reset byte_en", {28'd0, byte_en}, 32'h1);
    compare_all();

    // R3: big-endian lane numbering
    set_endian(1'b1);
    apply(2'd0, 2'd0, 1'b0, 32'h0, 32'h11223344);
    #1;
    check32("R3", "big byte load", ld_result, 32'h00000011);
    apply(2'd0, 2'd0, 1'b0, 32'h000000A5, 32'h0);
    #1;
    check32("R3", "big byte_en", {28'd0, byte_en}, 32'h8);
    check32("R3", "big byte wr", wr_data, 32'hA5000000);

    // R2: cfg_big moving without a strobe changes nothing
    @(negedge clk); cfg_big = 1'b0;
    @(negedge clk); cfg_big = 1'b1;
    @(negedge clk); cfg_big = 1'b0;
    apply(2'd0, 2'd0, 1'b0, 32'h0, 32'h11223344);
    @(negedge clk);
    check32("R2", "hold without strobe", ld_result, 32'h00000011);

    // R7/R8 sign extension, both modes
    apply(2'd0, 2'd3, 1'b1, 32'h0, 32'h80FFFF7F);  // big: offset 3 -> lane 0
    #1; check32("R7", "signed byte positive", ld_result, 32'h0000007F);
    apply(2'd1, 2'd2, 1'b1, 32'h0, 32'h1234F00D);  // big: offset 2 -> bits 15:0
    #1; check32("R8", "signed half", ld_result, 32'hFFFFF00D);
    apply(2'd1, 2'd2, 1'b0, 32'h0, 32'h1234F00D);
    #1; check32("R8", "unsigned half", ld_result, 32'h0000F00D);

    set_endian(1'b0);
    apply(2'd0, 2'd3, 1'b1, 32'h0, 32'h80FFFF7F);
    #1; check32("R7", "signed byte negative", ld_result, 32'hFFFFFF80);
    apply(2'd0, 2'd3, 1'b0, 32'h0, 32'h80FFFF7F);
    #1; check32("R7", "unsigned byte", ld_result, 32'h00000080);
    apply(2'd1, 2'd2, 1'b0, 32'h0000BEEF, 32'h0);
    #1; check32("R5", "half store wr", wr_data, 32'hBEEF0000);
    check32("R5", "half store be", {28'd0, byte_en}, 32'hC);

    // R10: odd halfword
    apply(2'd1, 2'd1, 1'b0, 32'h0000BEEF, 32'hCAFE1234);
    #1; check32("R10", "misalign flag", {31'd0, misalign}, 32'h1);
    check32("R10", "misalign be", {28'd0, byte_en}, 32'h0);
    check32("R10", "misalign load", ld_result, 32'h00001234);

    // R6/R9/R11: word accesses with nonzero offsets
    apply(2'd2, 2'd3, 1'b1, 32'hDEADBEEF, 32'h87654321);
    #1; check32("R6", "word store", wr_data, 32'hDEADBEEF);
    check32("R9", "word load", ld_result, 32'h87654321);
    apply(2'd3, 2'd1, 1'b1, 32'hDEADBEEF, 32'h87654321);
    #1; check32("R11", "code 3 be", {28'd0, byte_en}, 32'hF);
    check32("R11", "code 3 load", ld_result, 32'h87654321);

    // Random traffic compared with the model on every clock, with occasional
    // endianness writes and strobe-less cfg_big changes (R2).
    for (int i = 0; i < 4000; i++) begin
      logic nwr, nbig;
      nwr  = ($urandom % 16) == 0;
      nbig = $urandom;
      @(negedge clk);
      if (cfg_wr) mbig = cfg_big;
      compare_all();
      cfg_wr = nwr; cfg_big = nbig;
      apply(2'($urandom), 2'($urandom), 1'($urandom), $urandom, $urandom);
    end
    @(negedge clk);
    if (cfg_wr) mbig = cfg_big;
    compare_all();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule